// File: doc/BRIEF.md
# Trinomial-Field Karatsuba Multiplier

This block multiplies two elements of the binary extension field GF(2^M) given in polynomial basis. The field is defined by a trinomial x^M + x^K + 1, and K may lie anywhere strictly between 0 and M. Addition is bitwise XOR, so there are no carries anywhere.

Each operand is cut into N low segments of SEG bits and one high segment of REM bits, so that M = N·SEG + REM with 0 < REM < SEG. The high segment is zero-padded to SEG bits. The unreduced product of degree up to 2M−2 is built from the segment pairs with a multi-term Karatsuba scheme: one carry-less product per segment and one per pair of segment sums. It is then folded back below degree M by repeated use of x^M = x^K + 1. The number of folding passes is fixed at elaboration from M and K, and it grows when K is above M/2.

The arithmetic is combinational. A single output register carries the result on a valid/ready stream. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high, and its product appears on `out_data` one cycle later. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` is low, so back-pressure reaches the producer in the same cycle. Illegal parameter sets are rejected at elaboration.

Top module: `gf_trinomial_mul_stream`

## Requirements
- R1: For every accepted pair (a, b), `out_data` equals a·b reduced modulo x^M + x^K + 1. Bit i of each bus is the coefficient of x^i.
- R2: If either operand of an accepted pair is zero, the result is zero.
- R3: If one operand of an accepted pair is the constant 1 (value 1), the result equals the other operand.
- R4: The reduction is correct for K above M/2 as well as for K at or below M/2.
- R5: For single-bit operands x^i and x^j, the result is x^(i+j) reduced. The all-ones pair gives the field product of the all-ones element with itself.
- R6: The product is commutative: accepting (a, b) and then (b, a) yields equal results.
- R7: A transfer accepted on one clock edge makes `out_valid` high after that edge, carrying its product.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged and no new pair is taken.
- R9: While `rst_n` is low and directly after it rises, `out_valid` is low and `in_ready` is high.
- R10: An edge with `in_ready` high and `in_valid` low leaves `out_valid` low after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair can be taken this cycle |
| in_a | input | M | First operand, bit i is coefficient of x^i |
| in_b | input | M | Second operand |
| out_valid | output | 1 | Product on `out_data` is valid |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_data | output | M | Reduced product |

## Verification
The protocol assertions assume that the producer keeps `in_a` and `in_b` at known values while `in_valid` is high. They also assume that `out_ready` is never X. The algebraic assertions on zero and identity operands hold only when an accepted operand is exactly 0 or exactly 1. The bench drives every input from a task between clock edges and always assigns defined values. It checks each cycle against a behavioural model of the output register. Stimulus mixes stalls, idle cycles and back-pressure with directed operands, and two parameter sets run side by side: one with a low middle exponent and one with a high middle exponent.

// File: rtl/gfk_pkg.sv
package gfk_pkg;

  // Number of fold passes needed to bring degree 2m-2 below m with x^m = x^k + 1.
  function automatic int fold_passes(input int m, input int k);
    int d;
    int p;
    d = 2 * m - 2;
    p = 0;
    while (d >= m && p < 64) begin
      d = d - m + k;
      p = p + 1;
    end
    return p;
  endfunction

  // Flat index of the unordered segment pair (i, j), i < j, among ns segments.
  function automatic int pair_idx(input int ns, input int i, input int j);
    return i * ns - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

endpackage

// File: rtl/gfk_clmul.sv
module gfk_clmul #(
  parameter int W = 3
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
      end
    end
  end

endmodule

// File: rtl/gfk_kara_core.sv
module gfk_kara_core
  import gfk_pkg::*;
#(
  parameter int M   = 11,
  parameter int N   = 3,
  parameter int SEG = 3,
  parameter int REM = 2
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  output logic [2*M-2:0] prod
);

  localparam int NS = N + 1;
  localparam int PW = 2 * SEG - 1;
  localparam int QW = 2 * M - 1;
  localparam int NP = NS * (NS - 1) / 2;

  logic [SEG-1:0] sa [NS];
  logic [SEG-1:0] sb [NS];
  logic [PW-1:0]  dp [NS];
  logic [PW-1:0]  xp [NP];

  // Segmentation: N full low segments, one zero-padded remainder segment.
  for (genvar s = 0; s < N; s++) begin : g_seg
    assign sa[s] = a[s*SEG +: SEG];
    assign sb[s] = b[s*SEG +: SEG];
  end
  assign sa[N] = {{(SEG-REM){1'b0}}, a[M-1 -: REM]};
  assign sb[N] = {{(SEG-REM){1'b0}}, b[M-1 -: REM]};

  // One product per segment.
  for (genvar i = 0; i < NS; i++) begin : g_diag
    gfk_clmul #(.W(SEG)) u_mul (.a(sa[i]), .b(sb[i]), .p(dp[i]));
  end

  // One product per pair of segment sums.
  for (genvar i = 0; i < NS; i++) begin : g_row
    for (genvar j = i + 1; j < NS; j++) begin : g_col
      localparam int PI = pair_idx(NS, i, j);
      logic [SEG-1:0] sx;
      logic [SEG-1:0] sy;
      assign sx = sa[i] ^ sa[j];
      assign sy = sb[i] ^ sb[j];
      gfk_clmul #(.W(SEG)) u_mul (.a(sx), .b(sy), .p(xp[PI]));
    end
  end

  // Recombination: x^(2i*SEG) * D_i, and x^((i+j)*SEG) * (D_ij + D_i + D_j).
  always_comb begin
    logic [PW-1:0] term;
    prod = '0;
    for (int i = 0; i < NS; i++) begin
      for (int t = 0; t < PW; t++) begin
        if (2 * i * SEG + t < QW) prod[2*i*SEG+t] = prod[2*i*SEG+t] ^ dp[i][t];
      end
    end
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        term = xp[pair_idx(NS, i, j)] ^ dp[i] ^ dp[j];
        for (int t = 0; t < PW; t++) begin
          if ((i + j) * SEG + t < QW) prod[(i+j)*SEG+t] = prod[(i+j)*SEG+t] ^ term[t];
        end
      end
    end
  end

endmodule

// File: rtl/gfk_trinomial_reduce.sv
module gfk_trinomial_reduce
  import gfk_pkg::*;
#(
  parameter int M = 11,
  parameter int K = 2
) (
  input  logic [2*M-2:0] prod,
  output logic [M-1:0]   res
);

  localparam int W      = 2 * M - 1;
  localparam int PASSES = fold_passes(M, K);

  logic [W-1:0] st [PASSES+1];

  assign st[0] = prod;

  // Each pass folds every coefficient at degree >= M onto degrees i and i+K.
  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    logic [W-1:0] nxt;
    always_comb begin
      nxt = '0;
      nxt[M-1:0] = st[p][M-1:0];
      for (int i = 0; i < M - 1; i++) begin
        if (st[p][M+i]) begin
          nxt[i]   = ~nxt[i];
          nxt[i+K] = ~nxt[i+K];
        end
      end
    end
    assign st[p+1] = nxt;
  end

  assign res = st[PASSES][M-1:0];

  // R1: the pass count derived from M and K must leave nothing above degree M-1.
  always_comb begin
    a_r1_fully_folded: assert (st[PASSES][W-1:M] == '0)
      else $error("fold passes left high coefficients");
  end

endmodule

// File: rtl/gf_trinomial_mul_stream.sv
module gf_trinomial_mul_stream
  import gfk_pkg::*;
#(
  parameter int M   = 11,
  parameter int K   = 2,
  parameter int N   = 3,
  parameter int SEG = 3,
  parameter int REM = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [M-1:0] out_data
);

  if (!(M == N * SEG + REM && N > 1 && REM > 0 && REM < SEG && K > 0 && K < M)) begin : g_bad_cfg
    $error("illegal field/segment parameters");
  end

  logic [2*M-2:0] raw;
  logic [M-1:0]   red;
  logic           take;

  gfk_kara_core #(.M(M), .N(N), .SEG(SEG), .REM(REM)) u_core (
    .a(in_a), .b(in_b), .prod(raw)
  );

  gfk_trinomial_reduce #(.M(M), .K(K)) u_red (
    .prod(raw), .res(red)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= red;
  end

  a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_idle_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);

  a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_a == '0 || in_b == '0)) |=> (out_data == '0));

  a_r3_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == M'(1)) |=> (out_data == $past(in_b)));

endmodule

// File: tb/gf_trinomial_mul_stream_tb.sv
module gf_trinomial_mul_stream_tb;

  localparam int M    = 11;
  localparam int K_LO = 2;
  localparam int K_HI = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [M-1:0] in_a = '0;
  logic [M-1:0] in_b = '0;
  logic         in_ready, in_ready_hi;
  logic         out_valid, out_valid_hi;
  logic [M-1:0] out_data, out_data_hi;

  int vectors = 0;
  int fails   = 0;

  bit           mv = 1'b0;
  logic [M-1:0] md_lo = '0;
  logic [M-1:0] md_hi = '0;

  always #5 clk = ~clk;

  gf_trinomial_mul_stream #(.M(M), .K(K_LO), .N(3), .SEG(3), .REM(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  gf_trinomial_mul_stream #(.M(M), .K(K_HI), .N(2), .SEG(4), .REM(3)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_hi),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid_hi), .out_ready(out_ready),
    .out_data(out_data_hi)
  );

  // Bit-serial shift-and-add reference.
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b, input int k);
    logic [M:0]   aa;
    logic [M-1:0] r;
    aa = {1'b0, a};
    r  = '0;
    for (int i = 0; i < M; i++) begin
      if (b[i]) r = r ^ aa[M-1:0];
      aa = aa << 1;
      if (aa[M]) aa = aa ^ ((1 << M) | (1 << k) | 1);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a negedge: drive, check ready, cross one edge, check outputs.
  task automatic step(input logic [M-1:0] a, input logic [M-1:0] b,
                      input bit v, input bit rdy, input string tag);
    bit exp_ready;
    in_a = a; in_b = b; in_valid = v; out_ready = rdy;
    #1;
    exp_ready = !mv || rdy;
    chk(in_ready == exp_ready, "R8 ready", int'(in_ready), int'(exp_ready));
    chk(in_ready_hi == exp_ready, "R8 ready hi", int'(in_ready_hi), int'(exp_ready));
    if (v && exp_ready) begin
      mv    = 1'b1;
      md_lo = ref_mul(a, b, K_LO);
      md_hi = ref_mul(a, b, K_HI);
    end else if (rdy) begin
      mv = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == mv, "R7 valid", int'(out_valid), int'(mv));
    chk(out_valid_hi == mv, "R7 valid hi", int'(out_valid_hi), int'(mv));
    if (mv) begin
      chk(out_data == md_lo, tag, int'(out_data), int'(md_lo));
      chk(out_data_hi == md_hi, {"R4 ", tag}, int'(out_data_hi), int'(md_hi));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [M-1:0] ra, rb;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_valid_hi == 1'b0, "R9 valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 ready after reset", int'(in_ready), 1);

    // R2: zero operands
    step('0, 11'h5a3, 1, 1, "R2");
    step(11'h7ff, '0, 1, 1, "R2");
    // R3: identity
    step(11'd1, 11'h4c7, 1, 1, "R3");
    step(11'h2b9, 11'd1, 1, 1, "R3");
    // R5: all ones and single bits
    step('1, '1, 1, 1, "R5");
    for (int i = 0; i < M; i++) begin
      step(M'(1) << i, M'(1) << (M - 1 - i), 1, 1, "R5");
      step(M'(1) << i, M'(1) << i, 1, 1, "R5");
    end
    // R6: commutativity
    for (int i = 0; i < 8; i++) begin
      ra = M'($urandom); rb = M'($urandom);
      step(ra, rb, 1, 1, "R6");
      step(rb, ra, 1, 1, "R6");
    end
    // R8: back-pressure, second offer must be refused, held output then drains
    step(11'h123, 11'h456, 1, 1, "R8");
    step(11'h123, 11'h456, 1, 0, "R8");
    step(11'h3ff, 11'h001, 1, 0, "R8");
    step(11'h3ff, 11'h001, 0, 1, "R8");
    // R10: idle edge leaves output empty
    step(11'h0aa, 11'h055, 0, 1, "R10");
    // R1: random operands with random valid/ready
    for (int i = 0; i < 300; i++) begin
      step(M'($urandom), M'($urandom), ($urandom % 4) != 0, ($urandom % 3) != 0, "R1");
    end
    step('0, '0, 0, 1, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule